// File: doc/BRIEF.md
# Audio sample FIFO pair with DMA request levels

This block sits between a register/DMA bus and a serial audio formatter. It holds two independent queues of 32-bit sample words: a transmit queue filled by bus writes and drained by the formatter, and a receive queue filled by the formatter and drained by bus reads. Both directions share one data register address. A write to that address queues a transmit word. A read from it dequeues a receive word.

For each direction it compares the fill level against software-programmed levels. From those comparisons it drives a DMA request line and a more urgent panic line. It also reports fill-state flags, a coarse "needs service" flag chosen by a 2-bit threshold code, and sticky underflow and overflow errors. A maskable interrupt output collects the service flags and the errors. Software can flush either queue, and the flush takes effect after two bit-clock ticks. The serial side is modelled by a pop strobe (transmit) and a push strobe (receive), and bit-clock timing arrives as a single-cycle tick.

Top module: `pcm_fifo_dreq`

Word addresses on `reg_addr`:

| Address | Register |
|---|---|
| 0 | control/status |
| 1 | sample data |
| 2 | DMA levels |
| 3 | interrupt enable |
| 4 | interrupt flags |

Any other address reads as zero.

## Requirements
- R1: After reset both queues are empty, all four DMA outputs and `irq` are 0, and control/status reads 0x002A0000: bit 21 (transmit empty), bit 19 (transmit can accept) and bit 17 (transmit needs writing, threshold code 0) are set.
- R2: Words written to address 1 leave on `tx_word` in write order, one per `tx_pop`, registered on the clock edge that samples the strobe. Words pushed with `rx_push` return in order from reads of address 1. `reg_rdata` is registered and valid one cycle after `reg_rd`.
- R3: Each queue holds DEPTH (64) words. A bus write to a full transmit queue is dropped. Status bit 19 is 0 while the transmit queue is full, and status bit 22 (receive full) is 1 while the receive queue holds 64 words.
- R4: A `tx_pop` on an empty transmit queue outputs 0 and sets status bit 15 (transmit error). The bit stays set until a 1 is written to bit 15 of control/status or to bit 2 of the interrupt flags.
- R5: An `rx_push` on a full receive queue drops the word and sets status bit 16 (receive error). The bit stays set until a 1 is written to bit 16 of control/status or to bit 3 of the interrupt flags.
- R6: The DMA-levels register holds the receive request level in bits 6:0, the transmit request level in bits 14:8, the receive panic level in bits 22:16 and the transmit panic level in bits 30:24. `tx_dreq` is 1 while the transmit level is below the transmit request level. `rx_dreq` is 1 while the receive level is above the receive request level.
- R7: `tx_panic` and `rx_panic` use the same comparisons as R6, against the panic levels.
- R8: Control bit 9 (DMA enable) gates all four DMA outputs. While it is 0, all four outputs are 0.
- R9: Control bits 6:5 pick the transmit threshold and bits 8:7 the receive threshold. Codes 0, 1, 2 and 3 select marks of 1, DEPTH/4, 3*DEPTH/4 and DEPTH. Status bit 17 is set while the transmit level is below its mark. Status bit 18 is set while the receive level is at or above its mark.
- R10: Writing 1 to control bit 3 (transmit clear) or bit 4 (receive clear) leaves the level unchanged until the second `bit_tick` after the write. That tick empties the matching queue.
- R11: Interrupt enable and flag registers use bit 0 for transmit-needs-writing, bit 1 for receive-needs-reading, bit 2 for transmit error and bit 3 for receive error. Flags 0 and 1 latch their condition and are cleared by writing 1 while the condition is false. `irq` is the OR of enabled flags.
- R12: A read of address 1 with an empty receive queue returns 0 and removes nothing. Reads of other addresses never dequeue a receive word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| bit_tick | input | 1 | One pulse per serial bit clock |
| tx_pop | input | 1 | Formatter takes one transmit word |
| tx_word | output | 32 | Word handed to the formatter |
| rx_push | input | 1 | Formatter delivers one receive word |
| rx_word | input | 32 | Received word |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |
| tx_panic | output | 1 | Transmit panic request |
| rx_panic | output | 1 | Receive panic request |
| irq | output | 1 | Interrupt |

## Verification
The assertions assume that `bit_tick`, `tx_pop`, `rx_push`, `reg_wr` and `reg_rd` are single-cycle strobes sampled on the rising edge. They also assume that the reset lasts at least one edge before any strobe. The queue-bound and flush properties rely on DEPTH being a power of two. The bench changes every strobe on the falling edge and holds it for exactly one cycle. It issues bus accesses one at a time and keeps DEPTH at its default of 64, so these conditions always hold.

// File: rtl/pcmf_pkg.sv
package pcmf_pkg;
  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_DATA  = 3'd1,
    A_LVLS  = 3'd2,
    A_IEN   = 3'd3,
    A_IFLG  = 3'd4
  } reg_addr_e;

  // Level mark selected by a 2-bit threshold code
  function automatic int mark_for(input logic [1:0] code, input int depth);
    case (code)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return (3 * depth) / 4;
      default: return depth;
    endcase
  endfunction

  function automatic logic below(input int level, input logic [6:0] lim);
    return level < int'(lim);
  endfunction

  function automatic logic above(input int level, input logic [6:0] lim);
    return level > int'(lim);
  endfunction
endpackage

// File: rtl/pcmf_ring.sv
module pcmf_ring #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          push_ok,
  output logic          pop_ok
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW:0]   wp, rp;

  assign level   = wp - rp;
  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
    end
  end

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH);
  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
  assert_full_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> full && $stable(level));
endmodule

// File: rtl/pcmf_clear_timer.sv
module pcmf_clear_timer #(
  parameter int TICKS = 2,
  localparam int CW   = $clog2(TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic done
);
  logic [CW-1:0] cnt;

  assign done = tick && (cnt == CW'(1)) && !start;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (start)             cnt <= CW'(TICKS);
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assert_done_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> tick);
  assert_start_arms_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);
endmodule

// File: rtl/pcm_fifo_dreq.sv
module pcm_fifo_dreq #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  parameter int CLR_TICKS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [2:0]   reg_addr,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  input  logic         bit_tick,
  input  logic         tx_pop,
  output logic [W-1:0] tx_word,
  input  logic         rx_push,
  input  logic [W-1:0] rx_word,
  output logic         tx_dreq,
  output logic         rx_dreq,
  output logic         tx_panic,
  output logic         rx_panic,
  output logic         irq
);
  import pcmf_pkg::*;
  localparam int LW = $clog2(DEPTH) + 1;

  // configuration state
  logic [1:0] tx_thr, rx_thr;
  logic       dma_en;
  logic [6:0] rx_req_lvl, tx_req_lvl, rx_pan_lvl, tx_pan_lvl;
  logic [3:0] ien, iflg_lat;
  logic       tx_err, rx_err;

  // decoded bus events
  logic wr_ctrl, wr_data, wr_lvls, wr_ien, wr_iflg, rd_data;
  assign wr_ctrl = reg_wr && reg_addr == A_CTRL;
  assign wr_data = reg_wr && reg_addr == A_DATA;
  assign wr_lvls = reg_wr && reg_addr == A_LVLS;
  assign wr_ien  = reg_wr && reg_addr == A_IEN;
  assign wr_iflg = reg_wr && reg_addr == A_IFLG;
  assign rd_data = reg_rd && reg_addr == A_DATA;

  // queue signals, index 0 = transmit, 1 = receive
  logic [W-1:0]  q_din  [2];
  logic [W-1:0]  q_head [2];
  logic [LW-1:0] q_lvl  [2];
  logic [1:0] q_push, q_pop, q_flush, q_empty, q_full, q_push_ok, q_pop_ok;
  logic [1:0] clr_start;

  assign q_din[0]  = reg_wdata[W-1:0];
  assign q_din[1]  = rx_word;
  assign q_push    = {rx_push, wr_data};
  assign q_pop     = {rd_data, tx_pop};
  assign clr_start = {wr_ctrl && reg_wdata[4], wr_ctrl && reg_wdata[3]};

  for (genvar g = 0; g < 2; g++) begin : g_dir
    pcmf_ring #(.W(W), .DEPTH(DEPTH)) u_ring (
      .clk(clk), .rst_n(rst_n),
      .push(q_push[g]), .pop(q_pop[g]), .flush(q_flush[g]),
      .din(q_din[g]), .head(q_head[g]), .level(q_lvl[g]),
      .empty(q_empty[g]), .full(q_full[g]),
      .push_ok(q_push_ok[g]), .pop_ok(q_pop_ok[g])
    );
    pcmf_clear_timer #(.TICKS(CLR_TICKS)) u_clr (
      .clk(clk), .rst_n(rst_n), .start(clr_start[g]),
      .tick(bit_tick), .done(q_flush[g])
    );
  end

  // named events for checking
  logic tx_underflow, rx_overflow, tx_err_clr, rx_err_clr;
  assign tx_underflow = tx_pop && q_empty[0];
  assign rx_overflow  = rx_push && q_full[1];
  assign tx_err_clr   = (wr_ctrl && reg_wdata[15]) || (wr_iflg && reg_wdata[2]);
  assign rx_err_clr   = (wr_ctrl && reg_wdata[16]) || (wr_iflg && reg_wdata[3]);

  // threshold flags
  logic tx_need, rx_need;
  assign tx_need = int'(q_lvl[0]) <  mark_for(tx_thr, DEPTH);
  assign rx_need = int'(q_lvl[1]) >= mark_for(rx_thr, DEPTH);

  // DMA requests
  assign tx_dreq  = dma_en && below(int'(q_lvl[0]), tx_req_lvl);
  assign tx_panic = dma_en && below(int'(q_lvl[0]), tx_pan_lvl);
  assign rx_dreq  = dma_en && above(int'(q_lvl[1]), rx_req_lvl);
  assign rx_panic = dma_en && above(int'(q_lvl[1]), rx_pan_lvl);

  logic [3:0] iflg;
  assign iflg = {rx_err, tx_err, iflg_lat[1:0]};
  assign irq  = |(iflg & ien);

  logic [31:0] ctrl_view;
  always_comb begin
    ctrl_view        = '0;
    ctrl_view[6:5]   = tx_thr;
    ctrl_view[8:7]   = rx_thr;
    ctrl_view[9]     = dma_en;
    ctrl_view[15]    = tx_err;
    ctrl_view[16]    = rx_err;
    ctrl_view[17]    = tx_need;
    ctrl_view[18]    = rx_need;
    ctrl_view[19]    = !q_full[0];
    ctrl_view[20]    = !q_empty[1];
    ctrl_view[21]    = q_empty[0];
    ctrl_view[22]    = q_full[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_thr <= '0; rx_thr <= '0; dma_en <= 1'b0;
      rx_req_lvl <= '0; tx_req_lvl <= '0; rx_pan_lvl <= '0; tx_pan_lvl <= '0;
      ien <= '0; iflg_lat <= '0;
      tx_err <= 1'b0; rx_err <= 1'b0;
      tx_word <= '0; reg_rdata <= '0;
    end else begin
      if (wr_ctrl) begin
        tx_thr <= reg_wdata[6:5];
        rx_thr <= reg_wdata[8:7];
        dma_en <= reg_wdata[9];
      end
      if (wr_lvls) begin
        rx_req_lvl <= reg_wdata[6:0];
        tx_req_lvl <= reg_wdata[14:8];
        rx_pan_lvl <= reg_wdata[22:16];
        tx_pan_lvl <= reg_wdata[30:24];
      end
      if (wr_ien) ien <= reg_wdata[3:0];

      if (tx_underflow)    tx_err <= 1'b1;
      else if (tx_err_clr) tx_err <= 1'b0;
      if (rx_overflow)     rx_err <= 1'b1;
      else if (rx_err_clr) rx_err <= 1'b0;

      iflg_lat[0] <= tx_need || (iflg_lat[0] && !(wr_iflg && reg_wdata[0]));
      iflg_lat[1] <= rx_need || (iflg_lat[1] && !(wr_iflg && reg_wdata[1]));

      if (tx_pop) tx_word <= q_empty[0] ? '0 : q_head[0];

      if (reg_rd) begin
        case (reg_addr)
          A_CTRL:  reg_rdata <= ctrl_view;
          A_DATA:  reg_rdata <= q_empty[1] ? '0 : 32'(q_head[1]);
          A_LVLS:  reg_rdata <= {1'b0, tx_pan_lvl, 1'b0, rx_pan_lvl,
                                 1'b0, tx_req_lvl, 1'b0, rx_req_lvl};
          A_IEN:   reg_rdata <= {28'b0, ien};
          A_IFLG:  reg_rdata <= {28'b0, iflg};
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  assert_underflow_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underflow |=> (tx_word == '0) && tx_err);
  assert_tx_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err && !tx_err_clr) |=> tx_err);
  assert_rx_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && !rx_err_clr) |=> rx_err);
  assert_overflow_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |=> rx_err);
  assert_dma_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !(tx_dreq || rx_dreq || tx_panic || rx_panic));
  assert_empty_read_keeps_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && q_empty[1] && !rx_push) |=> q_empty[1]);
endmodule

// File: tb/pcm_fifo_dreq_tb.sv
`timescale 1ns/1ps
module pcm_fifo_dreq_tb;
  localparam int DEPTH = 64;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic bit_tick = 0, tx_pop = 0, rx_push = 0;
  logic [31:0] tx_word, rx_word = 0;
  logic tx_dreq, rx_dreq, tx_panic, rx_panic, irq;
  int checks = 0, failures = 0;
  bit finished = 0;
  logic [31:0] cfg = 0;

  always #10 clk = ~clk;

  pcm_fifo_dreq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bit_tick(bit_tick), .tx_pop(tx_pop), .tx_word(tx_word),
    .rx_push(rx_push), .rx_word(rx_word), .tx_dreq(tx_dreq),
    .rx_dreq(rx_dreq), .tx_panic(tx_panic), .rx_panic(rx_panic), .irq(irq)
  );

  function automatic int mark(input int code);
    if (code == 0) return 1;
    if (code == 1) return DEPTH / 4;
    if (code == 2) return DEPTH * 3 / 4;
    return DEPTH;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic pop(output logic [31:0] w);
    @(negedge clk); tx_pop = 1;
    @(negedge clk); tx_pop = 0; w = tx_word;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk); rx_push = 1; rx_word = w;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic tick();
    @(negedge clk); bit_tick = 1;
    @(negedge clk); bit_tick = 0;
  endtask

  task automatic flush_both();
    wr(0, cfg | 32'h18); tick(); tick();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d);
    check("R1 status", d, 32'h002A0000);
    check("R1 outputs", {tx_dreq, rx_dreq, tx_panic, rx_panic, irq}, 0);
  endtask

  task automatic t_order();
    logic [31:0] d;
    wr(1, 32'hA1); wr(1, 32'hB2); wr(1, 32'hC3);
    pop(d); check("R2 tx first", d, 32'hA1);
    pop(d); check("R2 tx second", d, 32'hB2);
    pop(d); check("R2 tx third", d, 32'hC3);
    push(32'h11); push(32'h22);
    rd(1, d); check("R2 rx first", d, 32'h11);
    rd(1, d); check("R2 rx second", d, 32'h22);
    rd(0, d); check("R2 rx drained", d[20], 0);
  endtask

  task automatic t_underflow();
    logic [31:0] d;
    pop(d); check("R4 zero word", d, 0);
    rd(0, d); check("R4 error set", d[15], 1);
    rd(0, d); check("R4 error sticky", d[15], 1);
    wr(0, cfg | (32'h1 << 15));
    rd(0, d); check("R4 w1c clears", d[15], 0);
  endtask

  task automatic t_full_tx();
    logic [31:0] d;
    bit ok = 1;
    for (int i = 0; i < DEPTH + 2; i++) wr(1, 32'h100 + i);
    rd(0, d); check("R3 tx full accept", d[19], 0);
    for (int i = 0; i < DEPTH; i++) begin
      pop(d);
      if (d !== 32'h100 + i) ok = 0;
    end
    check("R3 tx 64 words in order", ok, 1);
    rd(0, d); check("R3 tx empty after 64", d[21], 1);
    check("R3 no underflow", d[15], 0);
  endtask

  task automatic t_overflow_rx();
    logic [31:0] d;
    bit ok = 1;
    for (int i = 0; i < DEPTH + 1; i++) push(32'h200 + i);
    rd(0, d); check("R3 rx full flag", d[22], 1);
    check("R5 rx error set", d[16], 1);
    for (int i = 0; i < DEPTH; i++) begin
      rd(1, d);
      if (d !== 32'h200 + i) ok = 0;
    end
    check("R5 extra word dropped", ok, 1);
    rd(0, d); check("R5 error sticky", d[16], 1);
    wr(4, 32'h8);
    rd(0, d); check("R5 flag w1c clears", d[16], 0);
  endtask

  task automatic t_dreq_clear();
    logic [31:0] d;
    wr(2, 32'h10303020);
    rd(2, d); check("R6 level layout", d, 32'h10303020);
    check("R8 gated off", {tx_dreq, tx_panic, rx_dreq, rx_panic}, 0);
    cfg = 32'h200; wr(0, cfg);
    check("R6 tx dreq empty", tx_dreq, 1);
    check("R7 tx panic empty", tx_panic, 1);
    for (int i = 0; i < 16; i++) wr(1, i);
    check("R7 tx panic at 16", tx_panic, 0);
    check("R6 tx dreq at 16", tx_dreq, 1);
    for (int i = 0; i < 32; i++) wr(1, i);
    check("R6 tx dreq at 48", tx_dreq, 0);
    for (int i = 0; i < 32; i++) push(i);
    check("R6 rx dreq at 32", rx_dreq, 0);
    push(0);
    check("R6 rx dreq at 33", rx_dreq, 1);
    for (int i = 0; i < 15; i++) push(i);
    check("R7 rx panic at 48", rx_panic, 0);
    push(0);
    check("R7 rx panic at 49", rx_panic, 1);
    wr(0, cfg | 32'h18);
    check("R10 tx kept after write", tx_dreq, 0);
    tick();
    check("R10 rx kept after 1 tick", rx_dreq, 1);
    tick();
    check("R10 tx flushed", tx_dreq, 1);
    check("R10 rx flushed", rx_dreq, 0);
    rd(0, d); check("R10 both empty", {d[21], d[20]}, 2'b10);
    cfg = 0; wr(0, cfg);
    check("R8 disable", {tx_dreq, tx_panic}, 0);
  endtask

  task automatic t_thresholds();
    logic [31:0] d;
    cfg = (32'd1 << 5) | (32'd2 << 7); wr(0, cfg);
    for (int i = 0; i < mark(1) - 1; i++) wr(1, i);
    rd(0, d); check("R9 txw below mark", d[17], 1);
    wr(1, 0);
    rd(0, d); check("R9 txw at mark", d[17], 0);
    for (int i = 0; i < mark(2) - 1; i++) push(i);
    rd(0, d); check("R9 rxr below mark", d[18], 0);
    push(0);
    rd(0, d); check("R9 rxr at mark", d[18], 1);
    flush_both();
    cfg = 0; wr(0, cfg);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(3, 32'h4);
    check("R11 idle irq", irq, 0);
    pop(d);
    check("R11 txerr irq", irq, 1);
    wr(4, 32'h4);
    check("R11 txerr cleared", irq, 0);
    rd(0, d); check("R11 status err cleared", d[15], 0);
    wr(3, 32'h1);
    check("R11 txw irq", irq, 1);
    wr(1, 32'h55);
    wr(4, 32'h1);
    check("R11 txw w1c", irq, 0);
    rd(4, d); check("R11 flag bit0", d[0], 0);
    wr(3, 0);
    flush_both();
  endtask

  task automatic t_read_side();
    logic [31:0] d;
    rd(1, d); check("R12 empty read zero", d, 0);
    push(32'hCAFE);
    rd(0, d); check("R12 data present", d[20], 1);
    rd(2, d);
    rd(1, d); check("R12 no pop by others", d, 32'hCAFE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_order();
    t_underflow();
    t_full_tx();
    t_overflow_rx();
    t_dreq_clear();
    t_thresholds();
    t_irq();
    t_read_side();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL R2 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule